// File: doc/BRIEF.md
# Interrupt Mapping and Request Arbiter

The block takes in 64 level-sensitive interrupt lines and presents at most one of them at a time as an interrupt-vector request. Lines 0 to 31 come from expansion-bus slots and are grouped in fours, with one mapping register for each group. Lines 32 to 63 come from on-board devices, and each of these lines has its own mapping register. Bit 31 of every mapping register is an enable. A line can win arbitration only when its level is high and the enable of its register is set.

While no request is outstanding, the block scans upward from line 0 to line 63 on every cycle and registers the first eligible line as a one-hot request. The request then holds, even if its line falls, until software retires it. Software retires a request in one of two ways. It can write a clear register that matches the request: a whole group for the slot lines, the exact line for the on-board lines. It can also write the owning mapping register with the enable at zero. The block rescans in the same write cycle, so the next eligible line is requested on the following edge.

Registers sit on a 16-bit byte address with 32-bit data. In each register slot only the word at offset +4 is live. Slot-line map group g is at 0xC04+8g. On-board map k is at 0x1004+8k. Slot clear for group g is at 0x1404+32g. On-board clear k is at 0x1804+8k.

Top module: `irq_map_arbiter`

## Requirements
- R1: After reset, req_vec is zero and every enable is clear. A read of slot map group g returns 0x7C0|(g<<2). A read of on-board map k returns 0x7E0+k.
- R2: A map read returns the enable in bit 31 over the fixed low 31 bits. A map write changes only bit 31. The slot map for group g is at 0xC00+8g+4. The on-board map for line 32+k is at 0x1000+8k+4.
- R3: A line is requested only while its level is high and its map enable is set. Setting the enable of a pending line raises its request on the edge that takes the write.
- R4: While idle, the block registers a request for the lowest-numbered eligible line, with lines 0-31 ahead of 32-63. The request appears one edge after the line becomes eligible.
- R5: req_vec has at most one bit set. A request holds unchanged while its line falls or other lines rise, for as long as no register write retires it.
- R6: A map write with bit 31 at zero withdraws the request only if that register owns it: group match for slot lines, exact line for on-board lines. The block rescans in the same cycle.
- R7: A write to the slot clear at 0x1400+32g+4 retires the request only when request/4 equals g, and the block then rescans. Any other request stays.
- R8: A write to the on-board clear at 0x1800+8k+4 retires the request only if it is line 32+k, and the block then rescans.
- R9: Reads of +0 words, clear registers and unmapped addresses return zero. Writes to +0 words and unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_lvl | input | 64 | Interrupt line levels |
| req_vec | output | 64 | One-hot outstanding request, zero when idle |

## Verification
The bench builds the block with its package defaults: eight groups of four slot lines and 32 on-board lines. These defaults reach both halves of the priority scan, group-wide matching for slot clears, and exact matching for on-board clears. A behavioural model of the map enables and of the single outstanding request number is compared on every clock, for both the request vector and the read data. Directed steps then cover the non-matching clears, the non-owner disables, and the rescan that promotes a higher line after the lower one is retired.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
  localparam int N_PCI_GRP   = 8;
  localparam int PCI_GRP_SZ  = 4;
  localparam int N_OBD       = 32;
  localparam int N_PCI       = N_PCI_GRP * PCI_GRP_SZ;
  localparam int N_LINES     = N_PCI + N_OBD;
  localparam int ID_W        = $clog2(N_LINES);
  localparam int PGRP_W      = $clog2(N_PCI_GRP);
  localparam int OBD_W       = $clog2(N_OBD);
  localparam int IDX_W       = (PGRP_W > OBD_W) ? PGRP_W : OBD_W;
  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 32;
  localparam int MAP_STRIDE  = 8;
  localparam int PCLR_STRIDE = 32;
  localparam int OCLR_STRIDE = 8;
  localparam int ACTIVE_OFS  = 4;
  localparam logic [ADDR_W-1:0] PMAP_BASE = 16'h0C00;
  localparam logic [ADDR_W-1:0] OMAP_BASE = 16'h1000;
  localparam logic [ADDR_W-1:0] PCLR_BASE = 16'h1400;
  localparam logic [ADDR_W-1:0] OCLR_BASE = 16'h1800;
  localparam logic [DATA_W-2:0] PMAP_LOW  = 31'h7C0;
  localparam logic [DATA_W-2:0] OMAP_LOW  = 31'h7E0;

  typedef struct packed {
    logic             pmap_wr;
    logic             omap_wr;
    logic             pclr_wr;
    logic             oclr_wr;
    logic             en_bit;
    logic [IDX_W-1:0] idx;
  } reg_evt_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_map_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_we,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [N_LINES-1:0] line_en_nxt,
  output reg_evt_t           evt
);
  localparam int MS_SH = $clog2(MAP_STRIDE);
  localparam int PC_SH = $clog2(PCLR_STRIDE);
  localparam int OC_SH = $clog2(OCLR_STRIDE);

  logic [ADDR_W-1:0] off_pm, off_om, off_pc, off_oc;
  logic              pm_hit, om_hit, pc_hit, oc_hit;
  logic [PGRP_W-1:0] idx_pm, idx_pc;
  logic [OBD_W-1:0]  idx_om, idx_oc;

  logic [N_PCI_GRP-1:0] pci_en_q, pci_en_d;
  logic [N_OBD-1:0]     obd_en_q, obd_en_d;
  logic                 pci_ce, obd_ce;

  // address decode: each window is an offset from its base, slot-aligned
  always_comb begin
    off_pm = reg_addr - PMAP_BASE;
    off_om = reg_addr - OMAP_BASE;
    off_pc = reg_addr - PCLR_BASE;
    off_oc = reg_addr - OCLR_BASE;
    pm_hit = (off_pm < ADDR_W'(N_PCI_GRP * MAP_STRIDE)) &&
             (off_pm[MS_SH-1:0] == MS_SH'(ACTIVE_OFS));
    om_hit = (off_om < ADDR_W'(N_OBD * MAP_STRIDE)) &&
             (off_om[MS_SH-1:0] == MS_SH'(ACTIVE_OFS));
    pc_hit = (off_pc < ADDR_W'(N_PCI_GRP * PCLR_STRIDE)) &&
             (off_pc[PC_SH-1:0] == PC_SH'(ACTIVE_OFS));
    oc_hit = (off_oc < ADDR_W'(N_OBD * OCLR_STRIDE)) &&
             (off_oc[OC_SH-1:0] == OC_SH'(ACTIVE_OFS));
    idx_pm = off_pm[MS_SH +: PGRP_W];
    idx_om = off_om[MS_SH +: OBD_W];
    idx_pc = off_pc[PC_SH +: PGRP_W];
    idx_oc = off_oc[OC_SH +: OBD_W];
  end

  // write events handed to the request holder
  always_comb begin
    evt.pmap_wr = reg_we & pm_hit;
    evt.omap_wr = reg_we & om_hit;
    evt.pclr_wr = reg_we & pc_hit;
    evt.oclr_wr = reg_we & oc_hit;
    evt.en_bit  = reg_wdata[DATA_W-1];
    if (pm_hit)      evt.idx = IDX_W'(idx_pm);
    else if (om_hit) evt.idx = IDX_W'(idx_om);
    else if (pc_hit) evt.idx = IDX_W'(idx_pc);
    else             evt.idx = IDX_W'(idx_oc);
  end

  // enable next state
  always_comb begin
    pci_en_d = pci_en_q;
    obd_en_d = obd_en_q;
    pci_ce   = reg_we & pm_hit;
    obd_ce   = reg_we & om_hit;
    if (pci_ce) pci_en_d[idx_pm] = reg_wdata[DATA_W-1];
    if (obd_ce) obd_en_d[idx_om] = reg_wdata[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pci_en_q <= '0;
    else if (pci_ce) pci_en_q <= pci_en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      obd_en_q <= '0;
    else if (obd_ce) obd_en_q <= obd_en_d;
  end

  // per-line enable as seen after this cycle's write
  for (genvar i = 0; i < N_PCI; i++) begin : g_pci_line
    assign line_en_nxt[i] = pci_en_d[i / PCI_GRP_SZ];
  end
  for (genvar k = 0; k < N_OBD; k++) begin : g_obd_line
    assign line_en_nxt[N_PCI + k] = obd_en_d[k];
  end

  // read mux: only the live words of the map windows carry data
  always_comb begin
    reg_rdata = '0;
    if (pm_hit)
      reg_rdata = {pci_en_q[idx_pm], PMAP_LOW | ((DATA_W-1)'(idx_pm) << 2)};
    else if (om_hit)
      reg_rdata = {obd_en_q[idx_om], OMAP_LOW + (DATA_W-1)'(idx_om)};
  end
endmodule

// File: rtl/irq_pick_first.sv
module irq_pick_first #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] elig,
  output logic         pick_vld,
  output logic [W-1:0] pick_id
);
  always_comb begin
    pick_vld = 1'b0;
    pick_id  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick_vld = 1'b1;
        pick_id  = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_req_hold.sv
module irq_req_hold
  import irq_map_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  reg_evt_t           evt,
  input  logic               pick_vld,
  input  logic [ID_W-1:0]    pick_id,
  output logic [N_LINES-1:0] req_vec
);
  localparam int GRP_SH = $clog2(PCI_GRP_SZ);

  logic            req_vld_q, req_vld_d;
  logic [ID_W-1:0] req_id_q, req_id_d;
  logic            req_is_obd, grp_match, line_match, drop, ce;
  logic [ID_W-1:0] req_grp, req_oidx;

  always_comb begin
    req_is_obd = (req_id_q >= ID_W'(N_PCI));
    req_grp    = req_id_q >> GRP_SH;
    req_oidx   = req_id_q - ID_W'(N_PCI);
    grp_match  = !req_is_obd && (req_grp == ID_W'(evt.idx));
    line_match = req_is_obd && (req_oidx == ID_W'(evt.idx));
    drop = req_vld_q &&
           ((evt.pmap_wr && !evt.en_bit && grp_match) ||
            (evt.omap_wr && !evt.en_bit && line_match) ||
            (evt.pclr_wr && grp_match) ||
            (evt.oclr_wr && line_match));
    ce        = !req_vld_q || drop;
    req_vld_d = pick_vld;
    req_id_d  = pick_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_vld_q <= 1'b0;
      req_id_q  <= '0;
    end else if (ce) begin
      req_vld_q <= req_vld_d;
      req_id_q  <= req_id_d;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_req_dec
    assign req_vec[i] = req_vld_q && (req_id_q == ID_W'(i));
  end
endmodule

// File: rtl/irq_map_arbiter.sv
module irq_map_arbiter
  import irq_map_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_we,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [N_LINES-1:0] irq_lvl,
  output logic [N_LINES-1:0] req_vec
);
  logic               rst_n_sync;
  logic [N_LINES-1:0] line_en_nxt;
  logic [N_LINES-1:0] elig_nxt;
  reg_evt_t           evt;
  logic               pick_vld;
  logic [ID_W-1:0]    pick_id;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  irq_map_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_we      (reg_we),
    .reg_rdata   (reg_rdata),
    .line_en_nxt (line_en_nxt),
    .evt         (evt)
  );

  assign elig_nxt = irq_lvl & line_en_nxt;

  irq_pick_first #(.N(N_LINES), .W(ID_W)) u_pick (
    .elig     (elig_nxt),
    .pick_vld (pick_vld),
    .pick_id  (pick_id)
  );

  irq_req_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .evt      (evt),
    .pick_vld (pick_vld),
    .pick_id  (pick_id),
    .req_vec  (req_vec)
  );
endmodule

// File: rtl/irq_map_arbiter_chk.sv
module irq_map_arbiter_chk
  import irq_map_pkg::*;
(
  input logic               clk,
  input logic               rst_n_s,
  input logic               reg_we,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic [N_LINES-1:0] req_vec,
  input logic [N_LINES-1:0] elig
);
  // R5
  onehot_req_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(req_vec));

  // R5
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_vec != '0 && !reg_we) |=> (req_vec == $past(req_vec)));

  // R3
  serve_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_vec == '0 && elig != '0) |=> (req_vec != '0));

  // R4
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(rst_n_s) && $past(req_vec) == '0 && !$past(reg_we)) |->
      (req_vec == ($past(elig) & (~$past(elig) + 1'b1))));

  // R9
  dead_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr[2:0] != 3'd4) |-> (reg_rdata == '0));
endmodule

bind irq_map_arbiter irq_map_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_sync),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .req_vec   (req_vec),
  .elig      (elig_nxt)
);

// File: tb/tb_irq_map_arbiter.sv
`timescale 1ns/1ps
module tb_irq_map_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic [31:0] reg_rdata;
  logic [63:0] irq_lvl;
  logic [63:0] req_vec;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_map_arbiter dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_lvl(irq_lvl), .req_vec(req_vec)
  );

  // behavioural reference
  bit m_pen[8];
  bit m_oen[32];
  int m_req;

  function automatic bit m_line_en(int i);
    if (i < 32) return m_pen[i / 4];
    return m_oen[i - 32];
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (a >= 'hC00 && a < 'hC40 && a % 8 == 4)
      return {m_pen[(a - 'hC00) / 8], 31'('h7C0 | (((a - 'hC00) / 8) << 2))};
    if (a >= 'h1000 && a < 'h1100 && a % 8 == 4)
      return {m_oen[(a - 'h1000) / 8], 31'('h7E0 + (a - 'h1000) / 8)};
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pen[i]) m_pen[i] = 1'b0;
      foreach (m_oen[i]) m_oen[i] = 1'b0;
      m_req = -1;
    end else begin
      int a;
      bit drop;
      bit found;
      a = int'(reg_addr);
      drop = 1'b0;
      if (reg_we) begin
        if (a >= 'hC00 && a < 'hC40 && a % 8 == 4) begin
          m_pen[(a - 'hC00) / 8] = reg_wdata[31];
          if (!reg_wdata[31] && m_req >= 0 && m_req < 32 && m_req / 4 == (a - 'hC00) / 8) drop = 1'b1;
        end
        if (a >= 'h1000 && a < 'h1100 && a % 8 == 4) begin
          m_oen[(a - 'h1000) / 8] = reg_wdata[31];
          if (!reg_wdata[31] && m_req == 32 + (a - 'h1000) / 8) drop = 1'b1;
        end
        if (a >= 'h1400 && a < 'h1500 && a % 32 == 4)
          if (m_req >= 0 && m_req < 32 && m_req / 4 == (a - 'h1400) / 32) drop = 1'b1;
        if (a >= 'h1800 && a < 'h1900 && a % 8 == 4)
          if (m_req == 32 + (a - 'h1800) / 8) drop = 1'b1;
      end
      if (drop) m_req = -1;
      if (m_req < 0) begin
        found = 1'b0;
        for (int i = 0; i < 64; i++)
          if (!found && irq_lvl[i] && m_line_en(i)) begin
            m_req = i;
            found = 1'b1;
          end
      end
    end
  end

  function automatic logic [63:0] m_vec();
    if (m_req < 0) return 64'h0;
    return 64'h1 << m_req;
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (req_vec !== m_vec()) begin
        n_fail++;
        $display("FAIL R5 model req actual=%h expected=%h", req_vec, m_vec());
      end
      n_chk++;
      if (reg_rdata !== m_read(int'(reg_addr))) begin
        n_fail++;
        $display("FAIL R2 model rdata actual=%h expected=%h", reg_rdata, m_read(int'(reg_addr)));
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 16'h0; reg_wdata = 32'h0;
  endtask

  task automatic set_irq(int i, logic v);
    @(posedge clk); #1;
    irq_lvl[i] = v;
  endtask

  task automatic chk_req(string tag, logic [63:0] exp);
    @(posedge clk); #1;
    @(negedge clk);
    chk(tag, req_vec, exp);
  endtask

  task automatic chk_rd(string tag, logic [15:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(tag, 64'(reg_rdata), 64'(exp));
    @(posedge clk); #1;
    reg_addr = 16'h0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R5 actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; reg_addr = 16'h0; reg_wdata = 32'h0; reg_we = 1'b0; irq_lvl = 64'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    chk_req("R1 reset req", 64'h0);
    chk_rd("R1 pci map 3 init", 16'h0C1C, 32'h0000_07CC);
    chk_rd("R1 obd map 5 init", 16'h102C, 32'h0000_07E5);

    set_irq(5, 1'b1);
    chk_req("R3 disabled line ignored", 64'h0);
    wr(16'h0C0C, 32'h8000_0000);
    chk_req("R3 enabled line requested", 64'h1 << 5);
    chk_rd("R2 enable readback", 16'h0C0C, 32'h8000_07C4);
    wr(16'h0C0C, 32'h8000_1234);
    chk_rd("R2 low bits kept", 16'h0C0C, 32'h8000_07C4);

    wr(16'h0C04, 32'h8000_0000);
    set_irq(2, 1'b1);
    chk_req("R5 lower line does not preempt", 64'h1 << 5);
    set_irq(5, 1'b0);
    chk_req("R5 held after line falls", 64'h1 << 5);

    wr(16'h1404, 32'h0);
    chk_req("R7 other group clear ignored", 64'h1 << 5);
    wr(16'h1424, 32'h0);
    chk_req("R7 group clear retires, R4 rescan", 64'h1 << 2);

    set_irq(40, 1'b1);
    set_irq(33, 1'b1);
    set_irq(63, 1'b1);
    wr(16'h1044, 32'h8000_0000);
    wr(16'h100C, 32'h8000_0000);
    wr(16'h10FC, 32'h8000_0000);
    chk_req("R5 held while others rise", 64'h1 << 2);
    set_irq(2, 1'b0);
    wr(16'h1404, 32'h0);
    chk_req("R4 lowest on-board line", 64'h1 << 33);

    wr(16'h1844, 32'h0);
    chk_req("R8 mismatched clear ignored", 64'h1 << 33);
    set_irq(33, 1'b0);
    wr(16'h180C, 32'h0);
    chk_req("R8 exact clear retires", 64'h1 << 40);

    wr(16'h1014, 32'h0);
    chk_req("R6 non-owner disable ignored", 64'h1 << 40);
    wr(16'h1044, 32'h0);
    chk_req("R6 owner disable withdraws", 64'h1 << 63);

    chk_rd("R9 plus-zero word", 16'h0C08, 32'h0);
    chk_rd("R9 unmapped", 16'h3000, 32'h0);
    chk_rd("R9 clear reg reads zero", 16'h1844, 32'h0);
    wr(16'h1040, 32'h8000_0000);
    chk_rd("R9 plus-zero write ignored", 16'h1044, 32'h0000_07E8);
    chk_req("R9 req unaffected", 64'h1 << 63);

    set_irq(63, 1'b0);
    wr(16'h18FC, 32'h0);
    chk_req("R8 last clear leaves idle", 64'h0);

    set_irq(6, 1'b1);
    chk_req("R3 group 1 line", 64'h1 << 6);
    wr(16'h0C0C, 32'h0);
    chk_req("R6 group disable withdraws", 64'h0);

    repeat (4) @(posedge clk);
    summary();
  end
endmodule